// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames into system memory by walking a circular chain of descriptors. Each descriptor is four 32-bit words, and the host and the engine share it through an ownership flag. The engine fetches the descriptor that the current pointer names. If the engine owns it, the engine takes a byte stream from the receive side and stores each byte at the descriptor's buffer address. When the last byte of the frame has been stored, the engine writes back the byte count. It then hands the descriptor to the host by clearing the ownership flag, pulses a frame interrupt and follows the descriptor's next pointer. The ring closes because the host links the last descriptor back to the first.

The host loads the ring base while the engine is stopped and then issues a start pulse. Reception halts when the engine meets a descriptor the host still holds. After the host has returned descriptors, a fresh start pulse makes the engine fetch that same descriptor again. A stop pulse takes effect at the next point where no frame is in progress. A frame that does not fit its buffer is cut to the buffer's capacity and is flagged in the status word.

Top module: `rxr_ring_engine`

## Requirements
- R1: During reset and right after it, `running`, `rx_ready`, `irq_frame` and `mem_req` are all 0.
- R2: A `cfg_load` pulse while stopped copies `cfg_ring_base` into the current descriptor pointer, which `cur_desc` shows.
- R3: After a `cmd_start` pulse, the engine reads the four words of the current descriptor: status at +0, size/count at +4, buffer pointer at +8 and next pointer at +12. If bit 31 of the status word is 1 (engine owns it), the engine raises `rx_ready`, and `rx_ready` is only ever high while `running` is high.
- R4: Accepted byte k of a frame goes to byte address A = buffer pointer + k. It is stored by one write to word address A with bits 1:0 cleared, with `mem_be` having only bit A mod 4 set and the byte on data lane A mod 4 (little-endian lanes).
- R5: After the last stored byte, the engine writes the size/count word at +4 as {size field in bits 31:16, stored byte count in bits 15:0}. Only then does it write the status word at +0 with bit 31 = 0, bit 30 = overflow flag and all other bits 0.
- R6: `irq_frame` is high for exactly one cycle, the cycle after the status write, and once per frame.
- R7: After a frame the current pointer takes the descriptor's next pointer, so a ring of descriptors is revisited in order and wraps from the last to the first.
- R8: When a fetched status word has bit 31 = 0, the engine stops: `running` and `rx_ready` fall, no memory access happens, and `cur_desc` still names that descriptor. A later `cmd_start` fetches it again.
- R9: A frame longer than the descriptor's size field stores only the first size-field bytes, writes that number as the count, and sets overflow bit 30.
- R10: The usable buffer is also capped by the parameter `MAX_BUF`. With a larger size field, at most `MAX_BUF` bytes are stored, the count is `MAX_BUF` and bit 30 is set, while the size field is written back unchanged.
- R11: A `cmd_stop` pulse while waiting for a frame's first byte stops the engine at the next edge and leaves the descriptor untouched. A pulse during a frame lets the frame finish with full writeback and interrupt, after which the engine stops.
- R12: `cmd_start` and `cmd_stop` together while stopped leave the engine stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load ring base into current pointer (stopped only) |
| cfg_ring_base | input | AW | Byte address of the first descriptor |
| cmd_start | input | 1 | Start or resume pulse |
| cmd_stop | input | 1 | Stop pulse |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory access request, accepted every cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the read request |
| irq_frame | output | 1 | One-cycle frame-done interrupt |
| running | output | 1 | Engine is active |
| cur_desc | output | AW | Current descriptor pointer |

## Verification
The bench builds the engine with `MAX_BUF` = 64 and `AW` = 32. The small cap lets a 70-byte frame reach the parameter-limited truncation path with few cycles. Descriptor size fields of 16 reach the field-limited truncation path, and a size field of 0xFFFF checks that the cap wins over a larger field. A three-entry ring with one misaligned buffer brings lane selection, wraparound, ownership halts and both stop timings within a short run.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int DATA_W   = 32;
    localparam int OWN_BIT  = 31;
    localparam int OVF_BIT  = 30;
    localparam int FIELD_W  = 16;

    localparam logic [1:0] WSEL_STAT = 2'd0;
    localparam logic [1:0] WSEL_SIZE = 2'd1;
    localparam logic [1:0] WSEL_BUF  = 2'd2;
    localparam logic [1:0] WSEL_NEXT = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_SIZE,
        ST_RD_BUF,
        ST_RD_NEXT,
        ST_GOT_NEXT,
        ST_RECV,
        ST_WB_SIZE,
        ST_WB_STAT
    } rxr_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_RD,
        OP_WR_WORD,
        OP_WR_BYTE
    } rxr_op_e;
endpackage

// File: rtl/rxr_limit.sv
module rxr_limit #(
    parameter int MAX_BUF = 1536,
    parameter int FW      = 16
) (
    input  logic [FW-1:0] size_field,
    input  logic [FW-1:0] stored,
    output logic          full
);
    localparam logic [FW-1:0] CAP = FW'(MAX_BUF);

    logic [FW-1:0] eff_limit;

    always_comb begin
        eff_limit = (size_field > CAP) ? CAP : size_field;
        full      = (stored >= eff_limit);
    end
endmodule

// File: rtl/rxr_mem_port.sv
module rxr_mem_port
    import rxr_pkg::*;
#(
    parameter int AW = 32
) (
    input  rxr_op_e           op,
    input  logic [AW-1:0]     desc_ptr,
    input  logic [1:0]        word_sel,
    input  logic [AW-1:0]     byte_addr,
    input  logic [7:0]        byte_data,
    input  logic [DATA_W-1:0] word_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [3:0]        mem_be,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0] lane_hit;
    logic [AW-1:0]    desc_word_addr;
    logic [AW-1:0]    byte_word_addr;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_hit[l] = (byte_addr[1:0] == 2'(l));
    end

    assign desc_word_addr = desc_ptr + AW'({word_sel, 2'b00});
    assign byte_word_addr = {byte_addr[AW-1:2], 2'b00};

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        case (op)
            OP_RD: begin
                mem_req  = 1'b1;
                mem_addr = desc_word_addr;
                mem_be   = '1;
            end
            OP_WR_WORD: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_word_addr;
                mem_be    = '1;
                mem_wdata = word_data;
            end
            OP_WR_BYTE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = byte_word_addr;
                mem_be    = lane_hit;
                mem_wdata = {LANES{byte_data}};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [AW-1:0]     cfg_ring_base,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              rx_valid,
    input  logic              rx_last,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              full,
    output rxr_op_e           op,
    output logic [1:0]        word_sel,
    output logic [AW-1:0]     desc_ptr,
    output logic [AW-1:0]     byte_addr,
    output logic [DATA_W-1:0] word_data,
    output logic [FIELD_W-1:0] size_field,
    output logic [FIELD_W-1:0] stored,
    output logic              irq_frame,
    output logic              running
);
    typedef struct packed {
        rxr_state_e        st;
        logic [AW-1:0]     cur;
        logic [AW-1:0]     nxt;
        logic [AW-1:0]     bptr;
        logic [FIELD_W-1:0] size;
        logic [FIELD_W-1:0] cnt;
        logic              ovf;
        logic              in_frame;
        logic              stop_pend;
        logic              irq;
    } regs_t;

    localparam regs_t RST = '{st: ST_IDLE, default: '0};

    regs_t q, d;
    logic  stop_now;

    always_comb begin
        d         = q;
        d.irq     = 1'b0;
        op        = OP_NONE;
        word_sel  = WSEL_STAT;
        word_data = '0;
        rx_ready  = 1'b0;
        stop_now  = cmd_stop | q.stop_pend;

        if (cmd_stop) begin
            d.stop_pend = 1'b1;
        end

        case (q.st)
            ST_IDLE: begin
                d.stop_pend = 1'b0;
                if (cfg_load) begin
                    d.cur = cfg_ring_base;
                end
                if (cmd_start && !cmd_stop) begin
                    d.st = ST_RD_STAT;
                end
            end
            ST_RD_STAT: begin
                if (stop_now) begin
                    d.st = ST_IDLE;
                end else begin
                    op       = OP_RD;
                    word_sel = WSEL_STAT;
                    d.st     = ST_RD_SIZE;
                end
            end
            ST_RD_SIZE: begin
                if (!mem_rdata[OWN_BIT]) begin
                    d.st = ST_IDLE;
                end else begin
                    op       = OP_RD;
                    word_sel = WSEL_SIZE;
                    d.st     = ST_RD_BUF;
                end
            end
            ST_RD_BUF: begin
                d.size   = mem_rdata[DATA_W-1 -: FIELD_W];
                op       = OP_RD;
                word_sel = WSEL_BUF;
                d.st     = ST_RD_NEXT;
            end
            ST_RD_NEXT: begin
                d.bptr   = mem_rdata[AW-1:0];
                op       = OP_RD;
                word_sel = WSEL_NEXT;
                d.st     = ST_GOT_NEXT;
            end
            ST_GOT_NEXT: begin
                d.nxt      = mem_rdata[AW-1:0];
                d.cnt      = '0;
                d.ovf      = 1'b0;
                d.in_frame = 1'b0;
                d.st       = ST_RECV;
            end
            ST_RECV: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    d.in_frame = 1'b1;
                    if (!full) begin
                        op    = OP_WR_BYTE;
                        d.cnt = q.cnt + 1'b1;
                    end else begin
                        d.ovf = 1'b1;
                    end
                    if (rx_last) begin
                        d.st = ST_WB_SIZE;
                    end
                end else if (stop_now && !q.in_frame) begin
                    d.st = ST_IDLE;
                end
            end
            ST_WB_SIZE: begin
                op        = OP_WR_WORD;
                word_sel  = WSEL_SIZE;
                word_data = {q.size, q.cnt};
                d.st      = ST_WB_STAT;
            end
            ST_WB_STAT: begin
                op                 = OP_WR_WORD;
                word_sel           = WSEL_STAT;
                word_data          = '0;
                word_data[OVF_BIT] = q.ovf;
                d.irq              = 1'b1;
                d.cur              = q.nxt;
                d.st               = stop_now ? ST_IDLE : ST_RD_STAT;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST;
        end else begin
            q <= d;
        end
    end

    assign desc_ptr   = q.cur;
    assign byte_addr  = q.bptr + AW'(q.cnt);
    assign size_field = q.size;
    assign stored     = q.cnt;
    assign irq_frame  = q.irq;
    assign running    = (q.st != ST_IDLE);
endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine
    import rxr_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MAX_BUF = 1536
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_ring_base,
    input  logic          cmd_start,
    input  logic          cmd_stop,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    output logic          rx_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          irq_frame,
    output logic          running,
    output logic [AW-1:0] cur_desc
);
    rxr_op_e            op;
    logic [1:0]         word_sel;
    logic [AW-1:0]      desc_ptr;
    logic [AW-1:0]      byte_addr;
    logic [DATA_W-1:0]  word_data;
    logic [FIELD_W-1:0] size_field;
    logic [FIELD_W-1:0] stored;
    logic               full;

    rxr_ctrl #(.AW(AW)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_load      (cfg_load),
        .cfg_ring_base (cfg_ring_base),
        .cmd_start     (cmd_start),
        .cmd_stop      (cmd_stop),
        .rx_valid      (rx_valid),
        .rx_last       (rx_last),
        .rx_ready      (rx_ready),
        .mem_rdata     (mem_rdata),
        .full          (full),
        .op            (op),
        .word_sel      (word_sel),
        .desc_ptr      (desc_ptr),
        .byte_addr     (byte_addr),
        .word_data     (word_data),
        .size_field    (size_field),
        .stored        (stored),
        .irq_frame     (irq_frame),
        .running       (running)
    );

    rxr_limit #(.MAX_BUF(MAX_BUF), .FW(FIELD_W)) i_limit (
        .size_field (size_field),
        .stored     (stored),
        .full       (full)
    );

    rxr_mem_port #(.AW(AW)) i_mem_port (
        .op        (op),
        .desc_ptr  (desc_ptr),
        .word_sel  (word_sel),
        .byte_addr (byte_addr),
        .byte_data (rx_data),
        .word_data (word_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata)
    );

    assign cur_desc = desc_ptr;
endmodule

// File: rtl/rxr_ring_chk.sv
module rxr_ring_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic       cmd_stop,
    input logic       rx_ready,
    input logic       mem_req,
    input logic       mem_we,
    input logic [3:0] mem_be,
    input logic       irq_frame,
    input logic       running
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!running && !rx_ready && !mem_req && !irq_frame));

    // R3
    ready_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> running);

    // R4
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));

    // R6
    irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_frame |-> $past(mem_req && mem_we));

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_frame |=> !irq_frame);

    // R8
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !mem_req);

    // R12
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && cmd_start && cmd_stop) |=> !running);
endmodule

bind rxr_ring_engine rxr_ring_chk i_ring_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .rx_ready  (rx_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .irq_frame (irq_frame),
    .running   (running)
);

// File: tb/test_rxr_ring_engine.sv
module test_rxr_ring_engine;
    localparam int AW      = 32;
    localparam int CAP     = 64;
    localparam int D0      = 'h40;
    localparam int D1      = 'h50;
    localparam int D2      = 'h60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_ring_base = '0;
    logic        cmd_start = 1'b0;
    logic        cmd_stop = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        irq_frame, running;
    logic [31:0] cur_desc;

    always #4 clk = ~clk;

    rxr_ring_engine #(.AW(AW), .MAX_BUF(CAP)) i_rxr_ring_engine (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ring_base(cfg_ring_base),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_frame(irq_frame),
        .running(running), .cur_desc(cur_desc)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int n_irq   = 0;
    bit quiet   = 1'b0;
    bit done    = 1'b0;

    // behavioural memory, host writes share the same process
    logic [31:0] bmem [0:255];
    logic        host_we = 1'b0;
    logic [31:0] host_addr = '0;
    logic [31:0] host_data = '0;

    always @(posedge clk) begin
        if (host_we) bmem[host_addr[9:2]] <= host_data;
        if (mem_req && !mem_we) mem_rdata <= bmem[mem_addr[9:2]];
        if (mem_req && mem_we) begin
            for (int l = 0; l < 4; l++)
                if (mem_be[l]) bmem[mem_addr[9:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
        end
    end

    typedef struct {
        int          addr;
        logic [3:0]  be;
        logic [31:0] data;
        bit          stat;
    } exp_t;
    exp_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // reference monitor compared on every clock
    bit irq_pend = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit stat_now;
            bit exp_irq;
            stat_now = 1'b0;
            if (mem_req && mem_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected write", longint'(mem_addr), 0);
                end else begin
                    exp_t e;
                    logic [31:0] m;
                    e = exp_q.pop_front();
                    m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
                    chk(mem_addr == 32'(e.addr), "R4/R5 write address", longint'(mem_addr), longint'(e.addr));
                    chk(mem_be == e.be, "R4 byte enables", longint'(mem_be), longint'(e.be));
                    chk((mem_wdata & m) == (e.data & m), "R5 write data",
                        longint'(mem_wdata & m), longint'(e.data & m));
                    stat_now = e.stat;
                end
            end
            exp_irq  = irq_pend;
            irq_pend = stat_now;
            if (irq_frame) n_irq++;
            if (exp_irq || irq_frame) chk(irq_frame == exp_irq, "R6 irq timing", irq_frame, exp_irq);
            if (quiet && mem_req) chk(1'b0, "R8 access while stopped", longint'(mem_addr), 0);
        end
    end

    task automatic host_write(input int addr, input logic [31:0] data);
        host_we = 1'b1; host_addr = 32'(addr); host_data = data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic set_desc(input int d, input int size, input int bufa, input int nxt);
        host_write(d,      32'h8000_0000);
        host_write(d + 4,  32'(size) << 16);
        host_write(d + 8,  32'(bufa));
        host_write(d + 12, 32'(nxt));
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'(seed * 16 + k * 3 + 1);
    endfunction

    task automatic expect_frame(input int d, input int bufa, input int size, input int len, input int seed);
        int lim;
        int cnt;
        lim = (size > CAP) ? CAP : size;
        cnt = (len > lim) ? lim : len;
        for (int k = 0; k < cnt; k++) begin
            int a;
            a = bufa + k;
            exp_q.push_back('{addr: a & ~3, be: 4'(1 << (a & 3)), data: {4{pat(seed, k)}}, stat: 1'b0});
        end
        exp_q.push_back('{addr: d + 4, be: 4'hF, data: {16'(size), 16'(cnt)}, stat: 1'b0});
        exp_q.push_back('{addr: d, be: 4'hF, data: {1'b0, (len > lim), 30'd0}, stat: 1'b1});
    endtask

    task automatic send_frame(input int len, input int seed, input int stop_at);
        for (int k = 0; k < len; k++) begin
            rx_valid = 1'b1;
            rx_data  = pat(seed, k);
            rx_last  = (k == len - 1);
            cmd_stop = (k == stop_at);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
            cmd_stop = 1'b0;
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic wait_ready(input string tag);
        int n;
        n = 0;
        while (!rx_ready && n < 30) begin
            @(negedge clk);
            n++;
        end
        chk(rx_ready == 1'b1, tag, rx_ready, 1);
    endtask

    task automatic pulse_start(input bit with_stop);
        cmd_start = 1'b1;
        cmd_stop  = with_stop;
        @(negedge clk);
        cmd_start = 1'b0;
        cmd_stop  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        set_desc(D0, 64, 'h101, D1);
        set_desc(D1, 16, 'h180, D2);
        set_desc(D2, 16, 'h200, D0);
        chk(!running && !rx_ready && !irq_frame && !mem_req, "R1 reset state",
            {running, rx_ready, irq_frame, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!running && !rx_ready && !mem_req, "R1 after reset", {running, rx_ready, mem_req}, 0);

        // R2 ring base load
        cfg_load = 1'b1; cfg_ring_base = D0;
        @(negedge clk);
        cfg_load = 1'b0;
        chk(cur_desc == D0, "R2 ring base", cur_desc, D0);

        // R3 start and fetch
        pulse_start(1'b0);
        chk(running == 1'b1, "R3 running after start", running, 1);
        wait_ready("R3 ready after fetch");

        // R4 R5 R6 misaligned buffer
        expect_frame(D0, 'h101, 64, 5, 1);
        send_frame(5, 1, -1);
        wait_ready("R7 next descriptor ready");
        chk(cur_desc == D1, "R7 advance to second", cur_desc, D1);

        expect_frame(D1, 'h180, 16, 1, 2);
        send_frame(1, 2, -1);
        wait_ready("R7 third descriptor ready");
        chk(cur_desc == D2, "R7 advance to third", cur_desc, D2);

        // R9 field-limited truncation
        expect_frame(D2, 'h200, 16, 20, 3);
        send_frame(20, 3, -1);
        repeat (10) @(negedge clk);
        quiet = 1'b1;
        chk(running == 1'b0, "R8 halt on host-owned", running, 1'b0);
        chk(rx_ready == 1'b0, "R8 not ready when halted", rx_ready, 0);
        chk(cur_desc == D0, "R7 R8 wrapped pointer held", cur_desc, D0);
        chk(exp_q.size() == 0, "R5 R9 all writes seen", exp_q.size(), 0);
        chk(bmem[(D2 + 4) >> 2] == {16'd16, 16'd16}, "R9 count word", bmem[(D2 + 4) >> 2], {16'd16, 16'd16});
        repeat (5) @(negedge clk);
        quiet = 1'b0;

        // R10 parameter cap
        set_desc(D0, 'hFFFF, 'h100, D1);
        set_desc(D1, 16, 'h180, D2);
        set_desc(D2, 16, 'h200, D0);
        pulse_start(1'b0);
        wait_ready("R8 resume at same descriptor");
        chk(cur_desc == D0, "R8 resumed pointer", cur_desc, D0);
        expect_frame(D0, 'h100, 'hFFFF, 70, 4);
        send_frame(70, 4, -1);
        wait_ready("R10 next ready");
        chk(bmem[D0 >> 2] == 32'h4000_0000, "R10 overflow status", bmem[D0 >> 2], 32'h4000_0000);
        chk(bmem[(D0 + 4) >> 2] == 32'hFFFF_0040, "R10 count capped", bmem[(D0 + 4) >> 2], 32'hFFFF_0040);

        // R11 stop while waiting
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        quiet = 1'b1;
        chk(running == 1'b0, "R11 idle stop", running, 0);
        chk(rx_ready == 1'b0, "R11 not ready", rx_ready, 0);
        repeat (4) @(negedge clk);
        chk(bmem[D1 >> 2] == 32'h8000_0000, "R11 descriptor untouched", bmem[D1 >> 2], 32'h8000_0000);
        chk(cur_desc == D1, "R11 pointer kept", cur_desc, D1);

        // R12 start and stop together
        pulse_start(1'b1);
        repeat (3) @(negedge clk);
        chk(running == 1'b0, "R12 stop wins", running, 0);
        quiet = 1'b0;

        // R11 stop during frame
        pulse_start(1'b0);
        wait_ready("R11 restart ready");
        expect_frame(D1, 'h180, 16, 6, 5);
        send_frame(6, 5, 2);
        repeat (6) @(negedge clk);
        chk(running == 1'b0, "R11 stop after frame", running, 0);
        chk(cur_desc == D2, "R11 pointer advanced", cur_desc, D2);
        chk(exp_q.size() == 0, "R11 frame completed", exp_q.size(), 0);
        chk(n_irq == 5, "R6 one irq per frame", n_irq, 5);

        // R7 last in ring then halt on host-owned first
        pulse_start(1'b0);
        wait_ready("R7 third ready");
        expect_frame(D2, 'h200, 16, 3, 6);
        send_frame(3, 6, -1);
        repeat (12) @(negedge clk);
        chk(running == 1'b0, "R8 halt after wrap", running, 0);
        chk(cur_desc == D0, "R7 wrap to first", cur_desc, D0);
        chk(n_irq == 6, "R6 irq total", n_irq, 6);
        chk(exp_q.size() == 0, "R5 no missing writes", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule